// File: doc/BRIEF.md
# Sixteen-Bit Compare-Period Up-Counter

This block is a free-standing interval timer built around an up-counter whose period is set by a compare register rather than by a reload value. Software writes a second compare value to get an extra match strobe inside each period. It also writes a two-byte control register to start, stop or restart the count. Each count step is qualified by a tick input, so the counter can run from the core clock or from any slower enable.

Registers sit behind a small byte-addressed access port with a one- or two-byte width select. Every access is checked for width, for the target address, for reserved control bits and for an illegal start-and-load combination. An access that breaks a rule is discarded as a whole and answered with a one-cycle error flag. Two bytes are packed high byte first: the byte at the lower address travels in data bits 15:8. A single byte always travels in bits 7:0.

Top module: `cmp_timer16`

## Requirements
- R1: After reset every register and the counter read as 0, and acc_rdata, acc_err, period_pulse, cmpa_pulse and cmpb_pulse are low.
- R2: While the run bit (bit 7 of the control high byte, offset 0x85) is 1 and compare A is nonzero, the counter starts from 0 and rises by one on each clock in which tick is high.
- R3: On the tick where the counter plus one reaches or passes compare A (offset 0xC4), the counter returns to 0 and period_pulse and cmpa_pulse are high for that one cycle, giving one period every compare-A ticks.
- R4: With compare A equal to 0 the counter stays at 0 and none of the three pulses is raised.
- R5: cmpb_pulse is high for one cycle when the counter steps onto the value of compare B (offset 0xD4), only when compare B is nonzero and less than compare A.
- R6: Writing the control high byte with the run bit 0 clears the counter to 0 and holds it there; any accepted write of the control high byte restarts the count from 0.
- R7: A control write with both the run bit 7 and the load bit 6 of the high byte set raises acc_err and changes nothing.
- R8: A control write with any of bits 2:0 of the high byte, or any of bits 2, 3 or 5 of the low byte (offset 0x84), nonzero raises acc_err and changes no byte, including in a two-byte write.
- R9: The control register takes one-byte accesses at 0x84 or 0x85 and two-byte accesses only at 0x84, with the low byte in data bits 15:8 and the high byte in bits 7:0; a two-byte access at 0x85 raises acc_err and has no effect.
- R10: The compare registers take one- and two-byte accesses; a one-byte write loads bits 7:0 and clears the upper bits, and a one-byte read returns bits 7:0.
- R11: The mode-A (0xB4) and mode-B (0xB5) bytes are stored and read back with one-byte accesses; a two-byte access to either raises acc_err and has no effect.
- R12: The counter at 0xA4 is read-only: a read returns the count (bits 7:0 for one byte), and a write raises acc_err and leaves the count untouched.
- R13: An access to any other offset raises acc_err, and a read that raises acc_err returns 0.
- R14: acc_rdata and acc_err belong to the access presented in the previous cycle and are 0 otherwise. The pulses rise in the same cycle as the counter change they mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count qualifier; the counter steps only when high |
| acc_en | input | 1 | Access strobe for one cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_two | input | 1 | 1 for a two-byte access, 0 for one byte |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after the access |
| acc_err | output | 1 | Access error flag, the cycle after the access |
| period_pulse | output | 1 | One-cycle strobe at each period end |
| cmpa_pulse | output | 1 | One-cycle strobe when the count reaches compare A |
| cmpb_pulse | output | 1 | One-cycle strobe when the count reaches compare B |

## Verification
Read data and the error flag are due exactly one cycle after the access strobe, and the counter reads the value it held during the access cycle. The three pulses and the new count appear together in the cycle after the qualifying tick. The bench updates its behavioural model at the same rising edge as the design and compares every output at the following falling edge, so each result is checked in the cycle it is due and in no other. Directed checks use counter reads placed a known number of ticks after a restart. They also count pulses over fixed windows whose edges were worked out from the period and compare values.

// File: rtl/cmp_timer16_pkg.sv
package cmp_timer16_pkg;

   localparam int unsigned BUS_W   = 16;
   localparam int unsigned BYTE_W  = 8;

   localparam logic [7:0] OFS_CTL_LO = 8'h84;
   localparam logic [7:0] OFS_CTL_HI = 8'h85;
   localparam logic [7:0] OFS_COUNT  = 8'hA4;
   localparam logic [7:0] OFS_MODE_A = 8'hB4;
   localparam logic [7:0] OFS_MODE_B = 8'hB5;
   localparam logic [7:0] OFS_CMP_A  = 8'hC4;
   localparam logic [7:0] OFS_CMP_B  = 8'hD4;

   localparam int unsigned RUN_BIT  = 7;
   localparam int unsigned LOAD_BIT = 6;

   localparam logic [7:0] LO_RSV_MASK = 8'h2C;
   localparam logic [7:0] HI_RSV_MASK = 8'h07;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTL_LO,
      SEL_CTL_HI,
      SEL_COUNT,
      SEL_MODE_A,
      SEL_MODE_B,
      SEL_CMP_A,
      SEL_CMP_B
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_CTL_LO: s = SEL_CTL_LO;
         OFS_CTL_HI: s = SEL_CTL_HI;
         OFS_COUNT:  s = SEL_COUNT;
         OFS_MODE_A: s = SEL_MODE_A;
         OFS_MODE_B: s = SEL_MODE_B;
         OFS_CMP_A:  s = SEL_CMP_A;
         OFS_CMP_B:  s = SEL_CMP_B;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cmp_timer16_regs.sv
module cmp_timer16_regs
   import cmp_timer16_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic              acc_two,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [BUS_W-1:0]  acc_wdata,
   input  logic [CNT_W-1:0]  count_q,
   output logic              run_o,
   output logic              restart_o,
   output logic [CNT_W-1:0]  cmp_a_q,
   output logic [CNT_W-1:0]  cmp_b_q,
   output logic [BUS_W-1:0]  rdata_q,
   output logic              err_q
);

   logic [BYTE_W-1:0] ctl_lo_q, ctl_hi_q, mode_a_q, mode_b_q;
   logic [BYTE_W-1:0] ctl_lo_n, ctl_hi_n, mode_a_n, mode_b_n;
   logic [CNT_W-1:0]  cmp_a_n, cmp_b_n;
   logic [BUS_W-1:0]  rd_c;
   logic              bad_c, restart_c;
   logic              addr_hi_zero;
   reg_sel_e          sel;

   assign addr_hi_zero = ((acc_addr >> BYTE_W) == '0);
   assign sel          = addr_hi_zero ? decode_ofs(acc_addr[BYTE_W-1:0]) : SEL_NONE;

   always_comb begin
      ctl_lo_n  = ctl_lo_q;
      ctl_hi_n  = ctl_hi_q;
      mode_a_n  = mode_a_q;
      mode_b_n  = mode_b_q;
      cmp_a_n   = cmp_a_q;
      cmp_b_n   = cmp_b_q;
      rd_c      = '0;
      bad_c     = 1'b0;
      restart_c = 1'b0;
      if (acc_en) begin
         case (sel)
            SEL_CTL_LO: begin
               if (acc_wr) begin
                  if (acc_two) begin
                     ctl_lo_n  = acc_wdata[2*BYTE_W-1:BYTE_W];
                     ctl_hi_n  = acc_wdata[BYTE_W-1:0];
                     restart_c = 1'b1;
                  end else begin
                     ctl_lo_n = acc_wdata[BYTE_W-1:0];
                  end
               end else begin
                  rd_c = acc_two ? {ctl_lo_q, ctl_hi_q} : BUS_W'(ctl_lo_q);
               end
            end
            SEL_CTL_HI: begin
               if (acc_two)     bad_c = 1'b1;
               else if (acc_wr) begin
                  ctl_hi_n  = acc_wdata[BYTE_W-1:0];
                  restart_c = 1'b1;
               end
               else             rd_c = BUS_W'(ctl_hi_q);
            end
            SEL_COUNT: begin
               if (acc_wr) bad_c = 1'b1;
               else        rd_c  = acc_two ? BUS_W'(count_q) : BUS_W'(count_q[BYTE_W-1:0]);
            end
            SEL_MODE_A: begin
               if (acc_two)     bad_c    = 1'b1;
               else if (acc_wr) mode_a_n = acc_wdata[BYTE_W-1:0];
               else             rd_c     = BUS_W'(mode_a_q);
            end
            SEL_MODE_B: begin
               if (acc_two)     bad_c    = 1'b1;
               else if (acc_wr) mode_b_n = acc_wdata[BYTE_W-1:0];
               else             rd_c     = BUS_W'(mode_b_q);
            end
            SEL_CMP_A: begin
               if (acc_wr) cmp_a_n = acc_two ? acc_wdata[CNT_W-1:0] : CNT_W'(acc_wdata[BYTE_W-1:0]);
               else        rd_c    = acc_two ? BUS_W'(cmp_a_q) : BUS_W'(cmp_a_q[BYTE_W-1:0]);
            end
            SEL_CMP_B: begin
               if (acc_wr) cmp_b_n = acc_two ? acc_wdata[CNT_W-1:0] : CNT_W'(acc_wdata[BYTE_W-1:0]);
               else        rd_c    = acc_two ? BUS_W'(cmp_b_q) : BUS_W'(cmp_b_q[BYTE_W-1:0]);
            end
            default: bad_c = 1'b1;
         endcase
         if ((ctl_lo_n & LO_RSV_MASK) != '0)              bad_c = 1'b1;
         if ((ctl_hi_n & HI_RSV_MASK) != '0)              bad_c = 1'b1;
         if (ctl_hi_n[RUN_BIT] && ctl_hi_n[LOAD_BIT])      bad_c = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_lo_q <= '0;
         ctl_hi_q <= '0;
         mode_a_q <= '0;
         mode_b_q <= '0;
         cmp_a_q  <= '0;
         cmp_b_q  <= '0;
         rdata_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (acc_en && !bad_c) begin
            ctl_lo_q <= ctl_lo_n;
            ctl_hi_q <= ctl_hi_n;
            mode_a_q <= mode_a_n;
            mode_b_q <= mode_b_n;
            cmp_a_q  <= cmp_a_n;
            cmp_b_q  <= cmp_b_n;
         end
         rdata_q <= bad_c ? '0 : rd_c;
         err_q   <= bad_c;
      end
   end

   assign run_o     = ctl_hi_q[RUN_BIT];
   assign restart_o = restart_c && !bad_c;

endmodule

// File: rtl/cmp_timer16_match.sv
module cmp_timer16_match #(
   parameter int unsigned CNT_W       = 16,
   parameter bit          PERIOD_KIND = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             arm,
   input  logic [CNT_W:0]   nxt,
   input  logic [CNT_W-1:0] cmp,
   output logic             hit,
   output logic             pulse_q
);

   generate
      if (PERIOD_KIND) begin : g_period
         assign hit = adv && arm && (nxt >= {1'b0, cmp});
      end else begin : g_equal
         assign hit = adv && arm && (cmp != '0) && (nxt == {1'b0, cmp});
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit;
   end

endmodule

// File: rtl/cmp_timer16_core.sv
module cmp_timer16_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   output logic [CNT_W-1:0] count_q,
   output logic             period_q,
   output logic             match_b_q
);

   localparam int unsigned NXT_W  = CNT_W + 1;
   localparam int unsigned NUM_CH = 2;

   logic [NXT_W-1:0]  nxt;
   logic              adv;
   logic [NUM_CH-1:0] hit, pulse_q, arm;
   logic [CNT_W-1:0]  cmp_val [NUM_CH];

   assign nxt        = NXT_W'(count_q) + NXT_W'(1);
   assign adv        = run && !restart && tick && (cmp_a != '0);
   assign cmp_val[0] = cmp_a;
   assign cmp_val[1] = cmp_b;
   assign arm[0]     = 1'b1;
   assign arm[1]     = (cmp_b < cmp_a);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         cmp_timer16_match #(
            .CNT_W       (CNT_W),
            .PERIOD_KIND (c == 0)
         ) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .arm     (arm[c]),
            .nxt     (nxt),
            .cmp     (cmp_val[c]),
            .hit     (hit[c]),
            .pulse_q (pulse_q[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (restart || !run)  count_q <= '0;
      else if (adv)              count_q <= hit[0] ? '0 : nxt[CNT_W-1:0];
   end

   assign period_q  = pulse_q[0];
   assign match_b_q = pulse_q[1];

endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
   import cmp_timer16_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic              acc_two,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [15:0]       acc_wdata,
   output logic [15:0]       acc_rdata,
   output logic              acc_err,
   output logic              period_pulse,
   output logic              cmpa_pulse,
   output logic              cmpb_pulse
);

   generate
      if (CNT_W <= BYTE_W || CNT_W > BUS_W) begin : g_bad_cnt_w
         $error("cmp_timer16: CNT_W must lie in 9..16");
      end
      if (ADDR_W < BYTE_W) begin : g_bad_addr_w
         $error("cmp_timer16: ADDR_W must be at least 8");
      end
   endgenerate

   logic [CNT_W-1:0] count_w, cmp_a_w, cmp_b_w;
   logic             run_w, restart_w, period_w;

   cmp_timer16_regs #(
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (acc_en),
      .acc_wr    (acc_wr),
      .acc_two   (acc_two),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .count_q   (count_w),
      .run_o     (run_w),
      .restart_o (restart_w),
      .cmp_a_q   (cmp_a_w),
      .cmp_b_q   (cmp_b_w),
      .rdata_q   (acc_rdata),
      .err_q     (acc_err)
   );

   cmp_timer16_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .run       (run_w),
      .restart   (restart_w),
      .cmp_a     (cmp_a_w),
      .cmp_b     (cmp_b_w),
      .count_q   (count_w),
      .period_q  (period_w),
      .match_b_q (cmpb_pulse)
   );

   assign period_pulse = period_w;
   assign cmpa_pulse   = period_w;

endmodule

// File: rtl/cmp_timer16_chk.sv
module cmp_timer16_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_a,
   input logic [CNT_W-1:0] cmp_b,
   input logic             period_pulse,
   input logic             cmpb_pulse,
   input logic             acc_en,
   input logic             acc_err
);

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1)) || (count == '0));

   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      period_pulse |-> (count == '0));

   p_zero_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_a == '0) |=> !period_pulse && !cmpb_pulse);

   p_cmpb_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmpb_pulse |-> (count == $past(cmp_b)) && ($past(cmp_b) < $past(cmp_a)));

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (count == '0));

   p_err_late_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_en) |-> !acc_err);

endmodule

bind cmp_timer16 cmp_timer16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run_w),
   .count        (count_w),
   .cmp_a        (cmp_a_w),
   .cmp_b        (cmp_b_w),
   .period_pulse (period_pulse),
   .cmpb_pulse   (cmpb_pulse),
   .acc_en       (acc_en),
   .acc_err      (acc_err)
);

// File: tb/cmp_timer16_tb_top.sv
`timescale 1ns/1ps
module cmp_timer16_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        tick_alt = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, acc_two = 1'b0;
   logic [7:0]  acc_addr = 8'h00;
   logic [15:0] acc_wdata = 16'h0000;
   logic [15:0] acc_rdata;
   logic        acc_err, period_pulse, cmpa_pulse, cmpb_pulse;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

   cmp_timer16 dut_i (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .acc_en (acc_en), .acc_wr (acc_wr), .acc_two (acc_two),
      .acc_addr (acc_addr), .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata), .acc_err (acc_err),
      .period_pulse (period_pulse), .cmpa_pulse (cmpa_pulse), .cmpb_pulse (cmpb_pulse)
   );

   // behavioural reference model
   logic [7:0]  m_lo, m_hi, m_ma, m_mb;
   logic [15:0] m_ca, m_cb, m_cnt, m_rd;
   logic        m_err, m_per, m_pb;

   always @(posedge clk or negedge rst_n) begin : mdl
      logic [7:0]  n_lo, n_hi, n_ma, n_mb;
      logic [15:0] n_ca, n_cb, r;
      bit e, rs;
      int nx;
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_ma = 0; m_mb = 0; m_ca = 0; m_cb = 0; m_cnt = 0;
         m_rd = 0; m_err = 0; m_per = 0; m_pb = 0;
      end else begin
         n_lo = m_lo; n_hi = m_hi; n_ma = m_ma; n_mb = m_mb; n_ca = m_ca; n_cb = m_cb;
         r = 0; e = 0; rs = 0;
         if (acc_en) begin
            case (acc_addr)
               8'h84: if (acc_wr) begin
                         if (acc_two) begin n_lo = acc_wdata[15:8]; n_hi = acc_wdata[7:0]; rs = 1; end
                         else n_lo = acc_wdata[7:0];
                      end else r = acc_two ? {m_lo, m_hi} : {8'h00, m_lo};
               8'h85: if (acc_two) e = 1;
                      else if (acc_wr) begin n_hi = acc_wdata[7:0]; rs = 1; end
                      else r = {8'h00, m_hi};
               8'hA4: if (acc_wr) e = 1; else r = acc_two ? m_cnt : (m_cnt & 16'h00FF);
               8'hB4: if (acc_two) e = 1; else if (acc_wr) n_ma = acc_wdata[7:0]; else r = {8'h00, m_ma};
               8'hB5: if (acc_two) e = 1; else if (acc_wr) n_mb = acc_wdata[7:0]; else r = {8'h00, m_mb};
               8'hC4: if (acc_wr) n_ca = acc_two ? acc_wdata : (acc_wdata & 16'h00FF);
                      else r = acc_two ? m_ca : (m_ca & 16'h00FF);
               8'hD4: if (acc_wr) n_cb = acc_two ? acc_wdata : (acc_wdata & 16'h00FF);
                      else r = acc_two ? m_cb : (m_cb & 16'h00FF);
               default: e = 1;
            endcase
            if ((n_lo & 8'h2C) != 0 || (n_hi & 8'h07) != 0 || (n_hi & 8'hC0) == 8'hC0) e = 1;
            if (e) begin
               n_lo = m_lo; n_hi = m_hi; n_ma = m_ma; n_mb = m_mb; n_ca = m_ca; n_cb = m_cb;
               r = 0; rs = 0;
            end
         end
         m_per = 0; m_pb = 0;
         if (rs || !m_hi[7]) m_cnt = 0;
         else if (tick && m_ca != 0) begin
            nx = int'(m_cnt) + 1;
            if (nx >= int'(m_ca)) begin
               m_cnt = 0; m_per = 1;
            end else begin
               m_cnt = 16'(nx);
               if (m_cb != 0 && m_cb < m_ca && m_cnt == m_cb) m_pb = 1;
            end
         end
         m_lo = n_lo; m_hi = n_hi; m_ma = n_ma; m_mb = n_mb; m_ca = n_ca; m_cb = n_cb;
         m_rd = r; m_err = e;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         compared++;
         if (acc_rdata !== m_rd || acc_err !== m_err || period_pulse !== m_per ||
             cmpa_pulse !== m_per || cmpb_pulse !== m_pb) begin
            mismatched++;
            $display("FAIL %s cycle compare: actual rd=%h err=%b per=%b cmpa=%b cmpb=%b expected rd=%h err=%b per=%b cmpa=%b cmpb=%b",
                     cur_req, acc_rdata, acc_err, period_pulse, cmpa_pulse, cmpb_pulse,
                     m_rd, m_err, m_per, m_per, m_pb);
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input logic [7:0] a, input bit two, input logic [15:0] wd);
      acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_two = two; acc_wdata = wd;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; acc_two = 1'b0; acc_wdata = 16'h0000;
   endtask

   task automatic wr(input logic [7:0] a, input bit two, input logic [15:0] wd, input bit exp_err, input string req);
      cur_req = req;
      acc(1'b1, a, two, wd);
      chk(req, "write error flag", {15'b0, acc_err}, {15'b0, exp_err});
   endtask

   task automatic rd(input logic [7:0] a, input bit two, input logic [15:0] exp, input bit exp_err, input string req);
      cur_req = req;
      acc(1'b0, a, two, 16'h0000);
      chk(req, "read data", acc_rdata, exp);
      chk(req, "read error flag", {15'b0, acc_err}, {15'b0, exp_err});
   endtask

   task automatic count_pulses(input int n, output int np, output int na, output int nb);
      np = 0; na = 0; nb = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (period_pulse) np++;
         if (cmpa_pulse)   na++;
         if (cmpb_pulse)   nb++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL R14 watchdog: actual run still busy expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stim
      int np, na, nb;
      repeat (4) @(negedge clk);
      cur_req = "R1";
      chk("R1", "rdata in reset", acc_rdata, 16'h0000);
      chk("R1", "pulses in reset", {13'b0, period_pulse, cmpa_pulse, cmpb_pulse}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "err after reset", {15'b0, acc_err}, 16'h0000);
      rd(8'h84, 1'b1, 16'h0000, 1'b0, "R1");
      rd(8'hC4, 1'b1, 16'h0000, 1'b0, "R1");
      rd(8'hD4, 1'b1, 16'h0000, 1'b0, "R1");
      rd(8'hA4, 1'b1, 16'h0000, 1'b0, "R1");

      // R9 control register widths and byte order
      wr(8'h84, 1'b0, 16'h00D3, 1'b0, "R9");
      rd(8'h84, 1'b0, 16'h00D3, 1'b0, "R9");
      wr(8'h84, 1'b1, 16'h4148, 1'b0, "R9");
      rd(8'h84, 1'b1, 16'h4148, 1'b0, "R9");
      rd(8'h85, 1'b0, 16'h0048, 1'b0, "R9");
      wr(8'h85, 1'b1, 16'h0000, 1'b1, "R9");
      rd(8'h85, 1'b0, 16'h0048, 1'b0, "R9");
      rd(8'h85, 1'b1, 16'h0000, 1'b1, "R9");
      wr(8'h84, 1'b0, 16'h0000, 1'b0, "R9");

      // R10 compare register widths
      wr(8'hC4, 1'b1, 16'h1234, 1'b0, "R10");
      rd(8'hC4, 1'b1, 16'h1234, 1'b0, "R10");
      wr(8'hC4, 1'b0, 16'hABCD, 1'b0, "R10");
      rd(8'hC4, 1'b1, 16'h00CD, 1'b0, "R10");
      wr(8'hD4, 1'b1, 16'hBEEF, 1'b0, "R10");
      rd(8'hD4, 1'b0, 16'h00EF, 1'b0, "R10");

      // R11 mode A/B bytes
      wr(8'hB4, 1'b0, 16'h005A, 1'b0, "R11");
      rd(8'hB4, 1'b0, 16'h005A, 1'b0, "R11");
      wr(8'hB5, 1'b1, 16'h1111, 1'b1, "R11");
      rd(8'hB5, 1'b0, 16'h0000, 1'b0, "R11");
      rd(8'hB4, 1'b1, 16'h0000, 1'b1, "R11");

      // R4 compare A of zero
      wr(8'hC4, 1'b1, 16'h0000, 1'b0, "R4");
      wr(8'hD4, 1'b1, 16'h0000, 1'b0, "R4");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R4");
      count_pulses(20, np, na, nb);
      chk("R4", "pulse count", 16'(np + na + nb), 16'd0);
      rd(8'hA4, 1'b1, 16'h0000, 1'b0, "R4");

      // R2 counting from zero
      wr(8'hC4, 1'b1, 16'd10, 1'b0, "R2");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R2");
      repeat (7) @(negedge clk);
      rd(8'hA4, 1'b1, 16'd7, 1'b0, "R2");

      // R3 period of ten ticks
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R3");
      count_pulses(50, np, na, nb);
      chk("R3", "period pulses", 16'(np), 16'd5);
      chk("R3", "compare-A pulses", 16'(na), 16'd5);
      chk("R3", "compare-B pulses with B=0", 16'(nb), 16'd0);

      // R5 compare B
      wr(8'hD4, 1'b1, 16'd4, 1'b0, "R5");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R5");
      count_pulses(50, np, na, nb);
      chk("R5", "compare-B pulses B=4", 16'(nb), 16'd5);
      wr(8'hD4, 1'b1, 16'd9, 1'b0, "R5");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R5");
      count_pulses(50, np, na, nb);
      chk("R5", "compare-B pulses B=A-1", 16'(nb), 16'd5);
      wr(8'hD4, 1'b1, 16'd10, 1'b0, "R5");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R5");
      count_pulses(50, np, na, nb);
      chk("R5", "compare-B pulses B=A", 16'(nb), 16'd0);

      // R6 restart and stop
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R6");
      repeat (3) @(negedge clk);
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R6");
      repeat (2) @(negedge clk);
      rd(8'hA4, 1'b1, 16'd2, 1'b0, "R6");
      wr(8'h85, 1'b0, 16'h0000, 1'b0, "R6");
      count_pulses(20, np, na, nb);
      chk("R6", "pulses while stopped", 16'(np + nb), 16'd0);
      rd(8'hA4, 1'b1, 16'h0000, 1'b0, "R6");

      // R7 run together with load
      wr(8'h85, 1'b0, 16'h00C0, 1'b1, "R7");
      rd(8'h85, 1'b0, 16'h0000, 1'b0, "R7");
      rd(8'hA4, 1'b1, 16'h0000, 1'b0, "R7");

      // R8 reserved bits
      wr(8'h84, 1'b0, 16'h0004, 1'b1, "R8");
      wr(8'h84, 1'b0, 16'h0020, 1'b1, "R8");
      rd(8'h84, 1'b0, 16'h0000, 1'b0, "R8");
      wr(8'h85, 1'b0, 16'h0081, 1'b1, "R8");
      rd(8'h85, 1'b0, 16'h0000, 1'b0, "R8");
      wr(8'h84, 1'b1, 16'h1081, 1'b1, "R8");
      rd(8'h84, 1'b1, 16'h0000, 1'b0, "R8");

      // R12 counter read-only
      wr(8'hC4, 1'b1, 16'h0200, 1'b0, "R12");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R12");
      repeat (300) @(negedge clk);
      rd(8'hA4, 1'b0, 16'h002C, 1'b0, "R12");
      wr(8'hA4, 1'b1, 16'hFFFF, 1'b1, "R12");
      rd(8'hA4, 1'b1, 16'h012E, 1'b0, "R12");

      // R13 unmapped offsets
      rd(8'h10, 1'b1, 16'h0000, 1'b1, "R13");
      wr(8'h30, 1'b1, 16'h5555, 1'b1, "R13");
      rd(8'h86, 1'b0, 16'h0000, 1'b1, "R13");

      // R14 error flag arrives exactly one cycle after the access
      cur_req = "R14";
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 8'h31; acc_two = 1'b0; acc_wdata = 16'h0001;
      chk("R14", "err during access cycle", {15'b0, acc_err}, 16'h0000);
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
      chk("R14", "err one cycle later", {15'b0, acc_err}, 16'h0001);
      @(negedge clk);
      chk("R14", "err cleared after one cycle", {15'b0, acc_err}, 16'h0000);

      // R2 with a gated tick, checked by the model every cycle
      wr(8'hC4, 1'b1, 16'd6, 1'b0, "R2");
      wr(8'hD4, 1'b1, 16'd3, 1'b0, "R2");
      wr(8'h85, 1'b0, 16'h0080, 1'b0, "R2");
      tick_alt = 1'b1;
      cur_req = "R2";
      count_pulses(40, np, na, nb);
      chk("R3", "gated tick pulses pair", 16'(np), 16'(na));
      tick_alt = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule